// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models the command decoder and write state machine of a parallel NOR flash on a plain synchronous bus. A host drives chip select, a write strobe, a read strobe, a word address and a 16-bit data word. Each write carries a command byte in the low data byte, or the operand of a two-cycle command. Reads return either array contents, the 8-bit status register, or the one-time-programmable (OTP) area, depending on the read mode most recently selected.

Erase and program operations take a fixed number of clock cycles, set by parameters. During that time the block reports busy. A running block erase or word program can be suspended and later resumed. While an erase is suspended, a word program to another block can be started, and that program can itself be suspended. Each block has a lock bit. The two highest-numbered blocks are boot blocks, and they are also protected whenever the write-protect input is low. Refused operations and malformed command pairs leave sticky error bits in the status register until they are cleared by a command. The array is a small register file that resets to all ones.

Top module: `nor_cmd_fsm`

## Requirements
- R1: After reset `ready` is 1, the block is in array-read mode, every array and OTP word reads FFFFh, and the status register reads 80h.
- R2: A write of 70h selects status reads, FFh selects array reads and 90h selects OTP reads. The OTP word is indexed by the low address bits. A status read returns {8'h00, S}, where S[7]=ready, S[6]=erase suspended, S[5]=erase/sequence error, S[4]=program error, S[2]=program suspended, S[1]=lock error, and S[3]=S[0]=0. `rdata` is 0 whenever `cs` and `rd` are not both high.
- R3: 20h followed by D0h at an address in block b keeps the block busy for exactly N_ERASE cycles. It then sets every word of block b to FFFFh and leaves the other blocks unchanged. The block index is the upper address bits above the word bits.
- R4: 30h followed by D0h keeps the block busy for N_ERASE cycles and erases every block that is not protected at completion. B0h has no effect on a full-chip erase.
- R5: 40h or 10h, followed by a write of data d to address a, keeps the block busy for exactly N_PROG cycles. Afterwards word a holds its old value AND d.
- R6: B0h during a running program makes `ready` 1 at once and sets S[2]. D0h clears S[2] and S[7], and the program then completes with its effect.
- R7: B0h during a running block erase sets S[6] and `ready`. While suspended, array reads and programs to other blocks are accepted, and such a program can itself be suspended and resumed. A program to the suspended block is refused with S[4]. D0h resumes a suspended program before the erase.
- R8: 60h then 01h locks the addressed block, and 60h then D0h clears all block locks. Each lock operation is busy for N_PROG cycles. A program to a protected block sets S[1] and S[4], and an erase sets S[1] and S[5]. In both cases the contents stay unchanged.
- R9: While `wp_n` is 0, the two highest-numbered blocks are protected against erase and program, as if they were locked.
- R10: C0h followed by data and address programs the OTP word (AND semantics, N_PROG cycles). 60h then F1h sets the OTP lock. After that, C0h writes set S[1] and S[4] and change nothing.
- R11: A second cycle other than D0h after 20h or 30h, or other than 01h, D0h or F1h after 60h, sets S[5] and S[4], starts nothing, and leaves the block in status-read mode.
- R12: Error bits S[5], S[4] and S[1] stay set across later commands until a 50h write, accepted when not busy, clears them.
- R13: While busy, only 70h and B0h are acted on. Any other write, such as FFh, leaves the read mode unchanged.
- R14: `ready` always equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write strobe, sampled on the rising edge with cs |
| rd | input | 1 | Read strobe, enables rdata with cs |
| addr | input | BLK_BITS+WRD_BITS | Word address; upper BLK_BITS select the block |
| wdata | input | 16 | Command byte (low byte) or operand data |
| wp_n | input | 1 | Write protect, low protects the two boot blocks |
| rdata | output | 16 | Read data for the selected read mode |
| ready | output | 1 | High when no operation is running |

## Verification
The hardest state to reach is the nested one. It needs a block erase suspended, a program to a different block started and then suspended on top of it, and the two resumes issued in order. The stimulus reaches it by issuing each suspend a single write cycle after its confirm, while the busy counters are still far from expiry. Status is read after every step, and the result is then compared word by word against a shadow array. Refusals caused by lock bits, by the write-protect input and by the suspended-block rule are driven directly, around a constrained random program phase.

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm #(
  parameter int BLK_BITS = 2,
  parameter int WRD_BITS = 2,
  parameter int OTP_BITS = 2,
  parameter int N_ERASE  = 16,
  parameter int N_PROG   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs,
  input  logic                         we,
  input  logic                         rd,
  input  logic [BLK_BITS+WRD_BITS-1:0] addr,
  input  logic [15:0]                  wdata,
  input  logic                         wp_n,
  output logic [15:0]                  rdata,
  output logic                         ready
);
  localparam int AW      = BLK_BITS + WRD_BITS;
  localparam int N_BLK   = 1 << BLK_BITS;
  localparam int N_WORDS = 1 << AW;
  localparam int N_OTP   = 1 << OTP_BITS;
  localparam int CMAX    = (N_ERASE > N_PROG) ? N_ERASE : N_PROG;
  localparam int CW      = $clog2(CMAX + 1);
  localparam logic [N_BLK-1:0] BOOT = ~({N_BLK{1'b1}} >> 2);

  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_OTP} mode_t;
  typedef enum logic [2:0] {C_IDLE, C_ERASE, C_CHIP, C_PROG, C_LOCK, C_OTP} cmd_t;
  typedef enum logic [2:0] {P_WORD, P_OTP, P_LSET, P_LCLR, P_OLOCK} pk_t;

  mode_t mode;
  cmd_t  cmd_st;
  pk_t   p_kind;
  logic [15:0] mem [N_WORDS];
  logic [15:0] otp [N_OTP];
  logic [N_BLK-1:0] lock;
  logic otp_lock;
  logic e_act, e_susp, e_chip;
  logic [BLK_BITS-1:0] e_blk;
  logic [CW-1:0] e_cnt, p_cnt;
  logic p_act, p_susp;
  logic [AW-1:0] p_addr;
  logic [15:0] p_data;
  logic err5, err4, err1;

  logic wr, e_run, p_run, busy, can_setup, can_prog;
  logic [7:0] cb;
  logic [BLK_BITS-1:0] a_blk;
  logic [N_BLK-1:0] prot_v;
  logic [7:0] sr;

  assign wr        = cs & we;
  assign cb        = wdata[7:0];
  assign a_blk     = addr[AW-1:WRD_BITS];
  assign prot_v    = lock | (wp_n ? '0 : BOOT);
  assign e_run     = e_act & ~e_susp;
  assign p_run     = p_act & ~p_susp;
  assign busy      = e_run | p_run;
  assign can_setup = ~busy & ~e_act & ~p_act;
  assign can_prog  = ~busy & ~p_act;
  assign sr        = {~busy, e_susp, err5, err4, 1'b0, p_susp, err1, 1'b0};
  assign ready     = ~busy;

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      case (mode)
        M_ARRAY:  rdata = mem[addr];
        M_STATUS: rdata = {8'h00, sr};
        default:  rdata = otp[addr[OTP_BITS-1:0]];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_ARRAY;
      cmd_st   <= C_IDLE;
      p_kind   <= P_WORD;
      lock     <= '0;
      otp_lock <= 1'b0;
      e_act    <= 1'b0;
      e_susp   <= 1'b0;
      e_chip   <= 1'b0;
      e_blk    <= '0;
      e_cnt    <= '0;
      p_act    <= 1'b0;
      p_susp   <= 1'b0;
      p_addr   <= '0;
      p_data   <= '0;
      p_cnt    <= '0;
      err5     <= 1'b0;
      err4     <= 1'b0;
      err1     <= 1'b0;
      for (int i = 0; i < N_WORDS; i++) mem[i] <= '1;
      for (int i = 0; i < N_OTP; i++) otp[i] <= '1;
    end else begin
      if (wr) begin
        if (cmd_st == C_IDLE) begin
          case (cb)
            8'hFF: if (!busy) mode <= M_ARRAY;
            8'h70: mode <= M_STATUS;
            8'h90: if (!busy) mode <= M_OTP;
            8'h50: if (!busy) begin err5 <= 1'b0; err4 <= 1'b0; err1 <= 1'b0; end
            8'h20: if (can_setup) begin cmd_st <= C_ERASE; mode <= M_STATUS; end
            8'h30: if (can_setup) begin cmd_st <= C_CHIP;  mode <= M_STATUS; end
            8'h60: if (can_setup) begin cmd_st <= C_LOCK;  mode <= M_STATUS; end
            8'hC0: if (can_setup) begin cmd_st <= C_OTP;   mode <= M_STATUS; end
            8'h40, 8'h10: if (can_prog) begin cmd_st <= C_PROG; mode <= M_STATUS; end
            8'hB0: begin
              if (p_run) begin
                p_susp <= 1'b1;
                mode   <= M_STATUS;
              end else if (e_run && !e_chip) begin
                e_susp <= 1'b1;
                mode   <= M_STATUS;
              end
            end
            8'hD0: begin
              if (!busy && p_susp) begin
                p_susp <= 1'b0;
                mode   <= M_STATUS;
              end else if (!busy && e_susp) begin
                e_susp <= 1'b0;
                mode   <= M_STATUS;
              end
            end
            default: ;
          endcase
        end else begin
          cmd_st <= C_IDLE;
          mode   <= M_STATUS;
          case (cmd_st)
            C_ERASE, C_CHIP: begin
              if (cb != 8'hD0) begin
                err5 <= 1'b1;
                err4 <= 1'b1;
              end else if (cmd_st == C_ERASE && prot_v[a_blk]) begin
                err5 <= 1'b1;
                err1 <= 1'b1;
              end else begin
                e_act  <= 1'b1;
                e_susp <= 1'b0;
                e_chip <= (cmd_st == C_CHIP);
                e_blk  <= a_blk;
                e_cnt  <= CW'(N_ERASE);
              end
            end
            C_PROG: begin
              if (e_act && a_blk == e_blk) begin
                err4 <= 1'b1;
              end else if (prot_v[a_blk]) begin
                err4 <= 1'b1;
                err1 <= 1'b1;
              end else begin
                p_act  <= 1'b1;
                p_susp <= 1'b0;
                p_kind <= P_WORD;
                p_addr <= addr;
                p_data <= wdata;
                p_cnt  <= CW'(N_PROG);
              end
            end
            C_OTP: begin
              if (otp_lock) begin
                err4 <= 1'b1;
                err1 <= 1'b1;
              end else begin
                p_act  <= 1'b1;
                p_susp <= 1'b0;
                p_kind <= P_OTP;
                p_addr <= addr;
                p_data <= wdata;
                p_cnt  <= CW'(N_PROG);
              end
            end
            C_LOCK: begin
              if (cb == 8'h01 || cb == 8'hD0 || cb == 8'hF1) begin
                p_act  <= 1'b1;
                p_susp <= 1'b0;
                p_kind <= (cb == 8'h01) ? P_LSET : (cb == 8'hD0) ? P_LCLR : P_OLOCK;
                p_addr <= addr;
                p_cnt  <= CW'(N_PROG);
              end else begin
                err5 <= 1'b1;
                err4 <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end

      if (e_run) begin
        if (e_cnt == CW'(1)) begin
          e_act <= 1'b0;
          for (int i = 0; i < N_WORDS; i++) begin
            if (e_chip ? !prot_v[BLK_BITS'(i >> WRD_BITS)] : (BLK_BITS'(i >> WRD_BITS) == e_blk))
              mem[i] <= '1;
          end
        end else begin
          e_cnt <= e_cnt - CW'(1);
        end
      end

      if (p_run) begin
        if (p_cnt == CW'(1)) begin
          p_act <= 1'b0;
          case (p_kind)
            P_WORD:  mem[p_addr] <= mem[p_addr] & p_data;
            P_OTP:   otp[p_addr[OTP_BITS-1:0]] <= otp[p_addr[OTP_BITS-1:0]] & p_data;
            P_LSET:  lock[p_addr[AW-1:WRD_BITS]] <= 1'b1;
            P_LCLR:  lock <= '0;
            default: otp_lock <= 1'b1;
          endcase
        end else begin
          p_cnt <= p_cnt - CW'(1);
        end
      end
    end
  end

  AST_ERASE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd_st == C_ERASE && cb == 8'hD0 && !prot_v[a_blk]) |=> !ready); // R3
  AST_CHIP_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd_st == C_IDLE && cb == 8'hB0 && e_run && e_chip) |=> !ready); // R4
  AST_PROG_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd_st == C_IDLE && cb == 8'hB0 && p_run) |=> (ready && sr[2])); // R6
  AST_ONE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    !(e_run && p_run)); // R7
  AST_LOCK_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd_st == C_ERASE && cb == 8'hD0 && prot_v[a_blk]) |=> (ready && sr[1] && sr[5])); // R8
  AST_SEQ_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (cmd_st == C_ERASE || cmd_st == C_CHIP) && cb != 8'hD0) |=> (ready && sr[5] && sr[4] && mode == M_STATUS)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err5 && !(wr && cmd_st == C_IDLE && cb == 8'h50 && !busy)) |=> err5); // R12
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd_st == C_IDLE && cb == 8'h50 && !busy) |=> (sr[5:4] == 2'b00 && !sr[1])); // R12
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && cmd_st == C_IDLE && cb == 8'hFF) |=> $stable(mode)); // R13
endmodule

// File: tb/tb_nor_cmd_fsm.sv
module tb_nor_cmd_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 20;
  localparam int NP = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0, rd = 1'b0, wp_n = 1'b1;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic ready;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] mm [16];
  logic [15:0] om [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_fsm #(.BLK_BITS(2), .WRD_BITS(2), .OTP_BITS(2), .N_ERASE(NE), .N_PROG(NP)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .rd(rd), .addr(addr),
    .wdata(wdata), .wp_n(wp_n), .rdata(rdata), .ready(ready));

  function automatic logic [15:0] srv(bit rdy, bit es, bit e5, bit e4, bit ps, bit e1);
    return {8'h00, rdy, es, e5, e4, 1'b0, ps, e1, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcyc(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);
    wcyc(4'd0, {8'h00, c});
  endtask

  task automatic rcyc(input logic [3:0] a, output logic [15:0] d);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    #1 cs = 1'b0; rd = 1'b0;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic st_chk(input string req, input logic [15:0] exp);
    logic [15:0] d;
    rcyc(4'd0, d);
    chk(req, d, exp);
    chk("R14", {15'd0, ready}, {15'd0, d[7]});
  endtask

  task automatic arr_chk(input string req);
    logic [15:0] d;
    cmd(8'hFF);
    for (int i = 0; i < 16; i++) begin
      rcyc(4'(i), d);
      chk(req, d, mm[i]);
    end
  endtask

  task automatic prog(input logic [3:0] a, input logic [15:0] d, output int n);
    cmd(8'h40);
    wcyc(a, d);
    wait_rdy(n);
    mm[a] = mm[a] & d;
  endtask

  task automatic erase_model(input int b);
    for (int i = 0; i < 4; i++) mm[b*4 + i] = 16'hFFFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n;
    void'($urandom(32'd7315));
    for (int i = 0; i < 16; i++) mm[i] = 16'hFFFF;
    for (int i = 0; i < 4; i++) om[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 ready", {15'd0, ready}, 16'd1);
    chk("R2 idle rdata", rdata, 16'h0000);
    arr_chk("R1 array");
    cmd(8'h90);
    rcyc(4'd3, d); chk("R1 otp", d, 16'hFFFF);
    cmd(8'h70);
    st_chk("R1 status", srv(1, 0, 0, 0, 0, 0));

    prog(4'd5, 16'hA5F0, n);
    chk("R5 busy cycles", 16'(n), 16'(NP));
    cmd(8'h10); wcyc(4'd5, 16'h0FFF); wait_rdy(n); mm[5] = mm[5] & 16'h0FFF;
    cmd(8'hFF);
    rcyc(4'd5, d); chk("R5 and-program", d, 16'h05F0);

    for (int k = 0; k < 30; k++) begin
      logic [3:0] a;
      logic [15:0] v;
      a = 4'($urandom_range(0, 15));
      v = 16'($urandom);
      prog(a, v, n);
    end
    arr_chk("R5 random");

    cmd(8'h20); wcyc(4'd6, 16'h00D0); wait_rdy(n);
    chk("R3 busy cycles", 16'(n), 16'(NE));
    erase_model(1);
    arr_chk("R3 block erase");

    cmd(8'h20); wcyc(4'd0, 16'h00D0);
    cmd(8'hFF);
    st_chk("R13 ignored while busy", srv(0, 0, 0, 0, 0, 0));
    wait_rdy(n); erase_model(0);
    st_chk("R2 status ready", srv(1, 0, 0, 0, 0, 0));

    cmd(8'h40); wcyc(4'd1, 16'h1234);
    cmd(8'hB0);
    st_chk("R6 program suspended", srv(1, 0, 0, 0, 1, 0));
    cmd(8'hFF);
    rcyc(4'd1, d); chk("R6 no effect yet", d, 16'hFFFF);
    cmd(8'hD0);
    st_chk("R6 resumed busy", srv(0, 0, 0, 0, 0, 0));
    wait_rdy(n); mm[1] = mm[1] & 16'h1234;
    arr_chk("R6 completes");

    prog(4'd8, 16'h00FF, n);
    cmd(8'h20); wcyc(4'd8, 16'h00D0);
    cmd(8'hB0);
    st_chk("R7 erase suspended", srv(1, 1, 0, 0, 0, 0));
    cmd(8'hFF);
    rcyc(4'd8, d); chk("R7 read during suspend", d, mm[8]);
    cmd(8'h40); wcyc(4'd0, 16'hF0F0);
    cmd(8'hB0);
    st_chk("R7 nested suspend", srv(1, 1, 0, 0, 1, 0));
    cmd(8'hD0);
    st_chk("R7 program resumes first", srv(0, 1, 0, 0, 0, 0));
    wait_rdy(n); mm[0] = mm[0] & 16'hF0F0;
    st_chk("R7 back to erase suspend", srv(1, 1, 0, 0, 0, 0));
    cmd(8'h40); wcyc(4'd9, 16'h0000);
    st_chk("R7 suspended block refused", srv(1, 1, 0, 1, 0, 0));
    cmd(8'hD0);
    chk("R7 erase resumed", {15'd0, ready}, 16'd0);
    wait_rdy(n); erase_model(2);
    st_chk("R12 error sticky", srv(1, 0, 0, 1, 0, 0));
    cmd(8'h50);
    st_chk("R12 clear", srv(1, 0, 0, 0, 0, 0));
    arr_chk("R7 array after nest");

    cmd(8'h60); wcyc(4'd4, 16'h0001); wait_rdy(n);
    chk("R8 lock busy", 16'(n), 16'(NP));
    cmd(8'h40); wcyc(4'd4, 16'h0000);
    st_chk("R8 program refused", srv(1, 0, 0, 1, 0, 1));
    cmd(8'h50);
    cmd(8'h20); wcyc(4'd4, 16'h00D0);
    st_chk("R8 erase refused", srv(1, 0, 1, 0, 0, 1));
    cmd(8'h50);
    arr_chk("R8 unchanged");
    cmd(8'h60); wcyc(4'd0, 16'h00D0); wait_rdy(n);
    prog(4'd4, 16'h0F0F, n);
    arr_chk("R8 unlocked program");

    wp_n = 1'b0;
    cmd(8'h20); wcyc(4'd12, 16'h00D0);
    st_chk("R9 boot erase refused", srv(1, 0, 1, 0, 0, 1));
    cmd(8'h50);
    cmd(8'h40); wcyc(4'd8, 16'h0000);
    st_chk("R9 boot program refused", srv(1, 0, 0, 1, 0, 1));
    cmd(8'h50);
    cmd(8'h60); wcyc(4'd0, 16'h0001); wait_rdy(n);
    cmd(8'h30); wcyc(4'd0, 16'h00D0);
    cmd(8'hB0);
    chk("R4 suspend ignored", {15'd0, ready}, 16'd0);
    wait_rdy(n);
    chk("R4 busy cycles", 16'(n + 2), 16'(NE));
    erase_model(1);
    arr_chk("R4 chip erase");
    cmd(8'h60); wcyc(4'd0, 16'h00D0); wait_rdy(n);
    wp_n = 1'b1;

    cmd(8'hC0); wcyc(4'd1, 16'h3C3C); wait_rdy(n);
    chk("R10 otp busy", 16'(n), 16'(NP));
    om[1] = 16'h3C3C;
    cmd(8'h90);
    rcyc(4'd1, d); chk("R10 otp program", d, om[1]);
    cmd(8'h60); wcyc(4'd0, 16'h00F1); wait_rdy(n);
    cmd(8'hC0); wcyc(4'd2, 16'h0000);
    st_chk("R10 otp locked", srv(1, 0, 0, 1, 0, 1));
    cmd(8'h90);
    rcyc(4'd2, d); chk("R10 otp unchanged", d, om[2]);
    cmd(8'h50);

    cmd(8'h20); wcyc(4'd0, 16'h0077);
    rcyc(4'd0, d); chk("R11 bad erase confirm", d, srv(1, 0, 1, 1, 0, 0));
    cmd(8'h50);
    cmd(8'h60); wcyc(4'd0, 16'h0055);
    st_chk("R11 bad lock confirm", srv(1, 0, 1, 1, 0, 0));
    cmd(8'hFF); cmd(8'h70);
    st_chk("R12 errors persist", srv(1, 0, 1, 1, 0, 0));
    cmd(8'h50);
    st_chk("R12 cleared", srv(1, 0, 0, 0, 0, 0));
    arr_chk("R11 nothing started");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule